// File: doc/BRIEF.md
# Multi-Way Stream Buffer Prefetcher

This block sits next to a primary data cache and keeps prefetched blocks in a set of small circular FIFOs, called stream buffers, so that speculative data never displaces lines in the cache. Each primary-cache miss is offered to the block as a block address. Only the oldest entry of each buffer, its head, is compared with that address. A head match returns the block to the cache, frees that entry, and issues a prefetch for the block one buffer depth beyond it into the freed entry. If the head entry's data has not yet returned from memory, the block stalls until it does.

A miss that matches no head is answered as a miss. It is also recorded in a short history of recent miss addresses. A new stream starts only when the previous block address is still in that history, which means two misses on consecutive blocks. The least recently used buffer is then claimed and refilled with the blocks that follow. Every memory request carries a tag naming the buffer, the entry and the buffer's generation. Returned data whose generation is out of date, because its buffer was claimed again in the meantime, is dropped.

Top module: `stream_prefetch`

## Requirements
- R1: After reset `miss_ready` is 1, `resp_valid` and `mem_req_valid` are 0, all buffers are empty, and the first miss is answered with `resp_hit` = 0.
- R2: A miss accepted on a rising edge (`miss_valid` and `miss_ready` both 1) whose block address equals a head entry that already holds data is answered at the next edge with `resp_valid` = 1, `resp_hit` = 1 and that block's data on `resp_data`. The entry behind it becomes the new head.
- R3: After a head hit, a request for the block address of the consumed head plus DEPTH is issued into the freed entry, and its tag carries that entry's slot number.
- R4: An accepted miss that matches no head is answered at the next edge with `resp_valid` = 1 and `resp_hit` = 0.
- R5: A stream is allocated for a missing block m only if m-1 is among the last HIST addresses that were answered as misses. The history drops its oldest address first, and head hits are not recorded.
- R6: An allocation requests blocks m+1 to m+DEPTH in that order into slots 0 to DEPTH-1. Each request tag is {generation, buffer index, slot} from MSB to LSB, so with the bench parameters it is gen[4:3], buffer[2:1], slot[0]. A buffer's generation starts at 0 after reset and increments (mod 2^GW) on every allocation of that buffer.
- R7: Allocation claims the least recently used buffer. A buffer counts as used when it is allocated or its head hits. After reset the order of victims is buffer NBUF-1 down to buffer 0.
- R8: If a matched head is still waiting for memory, `miss_ready` goes to 0 and no response is given until the fill arrives. The hit is then answered with the filled data.
- R9: A fill whose tag generation differs from the current generation of the buffer it names is discarded and leaves that buffer's entries unchanged.
- R10: Only head entries are compared. A miss on a block held in a non-head entry is answered as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Primary-cache miss offered |
| miss_addr | input | AW | Block address of the miss |
| miss_ready | output | 1 | Block can accept a miss this cycle |
| resp_valid | output | 1 | Answer to an accepted miss |
| resp_hit | output | 1 | 1 if a stream buffer supplied the block |
| resp_data | output | DW | Block data when `resp_hit` is 1 |
| mem_req_valid | output | 1 | Prefetch request to memory |
| mem_req_addr | output | AW | Block address requested |
| mem_req_tag | output | GW+log2(NBUF)+log2(DEPTH) | {generation, buffer, slot} of the target entry |
| mem_fill_valid | input | 1 | Memory returns a block |
| mem_fill_tag | input | GW+log2(NBUF)+log2(DEPTH) | Tag copied from the request |
| mem_fill_data | input | DW | Returned block data |

## Verification
The bench builds the block with four buffers of depth two, a four-entry history, 16-bit block addresses and a 2-bit generation. With only four buffers, a full LRU cycle through every buffer and back to the first fits in a handful of misses. This lets a held-back memory return stale fills for a buffer that has already been claimed again, which exercises the generation check. The memory model can hold its fills, which keeps a head entry pending long enough to observe the stall. Four unrelated misses are enough to push an address out of the history.

// File: rtl/stream_pf_pkg.sv
package stream_pf_pkg;

  // Life of one buffer entry
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,  // no address
    SLOT_WANT  = 2'd1,  // address known, request not yet sent
    SLOT_PEND  = 2'd2,  // request sent, data outstanding
    SLOT_READY = 2'd3   // data present
  } slot_st_e;

  typedef enum logic {
    FSM_IDLE = 1'b0,
    FSM_WAIT = 1'b1
  } fsm_e;

endpackage

// File: rtl/sp_first_set.sv
module sp_first_set #(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/sp_miss_history.sv
module sp_miss_history #(
  parameter int AW    = 26,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit
);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (push) begin
      addr_q[0] <= push_addr;
      for (int i = 1; i < DEPTH; i++) addr_q[i] <= addr_q[i-1];
      vld_q <= {vld_q[DEPTH-2:0], 1'b1};
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (addr_q[i] == probe_addr);
  end

  assign probe_hit = |hit_vec;

endmodule

// File: rtl/sp_lru_rank.sv
module sp_lru_rank #(
  parameter  int NBUF = 8,
  localparam int BW   = $clog2(NBUF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [BW-1:0] touch_idx,
  output logic [BW-1:0] victim
);

  // rank 0 = most recent, NBUF-1 = least recent
  logic [BW-1:0] rank_q [NBUF];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBUF; i++) rank_q[i] <= BW'(i);
    end else if (touch) begin
      for (int i = 0; i < NBUF; i++) begin
        if (BW'(i) == touch_idx)              rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (rank_q[i] == BW'(NBUF - 1)) victim = BW'(i);
    end
  end

endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch
  import stream_pf_pkg::*;
#(
  parameter  int AW    = 26,
  parameter  int DW    = 64,
  parameter  int NBUF  = 8,
  parameter  int DEPTH = 2,
  parameter  int HIST  = 4,
  parameter  int GW    = 2,
  localparam int BW    = $clog2(NBUF),
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TW    = GW + BW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  output logic          miss_ready,
  output logic          resp_valid,
  output logic          resp_hit,
  output logic [DW-1:0] resp_data,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  output logic [TW-1:0] mem_req_tag,
  input  logic          mem_fill_valid,
  input  logic [TW-1:0] mem_fill_tag,
  input  logic [DW-1:0] mem_fill_data
);

  localparam int NSLOT = NBUF * DEPTH;
  localparam int FW    = $clog2(NSLOT);

  // Entry storage, flattened as buffer*DEPTH + slot
  slot_st_e      slot_st   [NSLOT];
  logic [AW-1:0] slot_addr [NSLOT];
  logic [DW-1:0] data_mem  [NSLOT];
  logic [SW-1:0] head_q    [NBUF];
  logic [GW-1:0] gen_q     [NBUF];
  fsm_e          fsm_q;
  logic [BW-1:0] wait_buf_q;

  function automatic logic [FW-1:0] flat(input logic [BW-1:0] b, input logic [SW-1:0] s);
    return FW'(b) * FW'(DEPTH) + FW'(s);
  endfunction

  // Head comparison, one comparator per buffer
  logic [NBUF-1:0] head_match;
  logic            hit_any;
  logic [BW-1:0]   hit_buf;

  for (genvar b = 0; b < NBUF; b++) begin : g_head
    logic [FW-1:0] hf;
    assign hf            = flat(BW'(b), head_q[b]);
    assign head_match[b] = (slot_st[hf] != SLOT_EMPTY) && (slot_addr[hf] == miss_addr);
  end

  sp_first_set #(.N(NBUF)) u_hit_pick (
    .req (head_match),
    .any (hit_any),
    .idx (hit_buf)
  );

  // Request issue: lowest-numbered entry waiting to be sent
  logic [NSLOT-1:0] want;
  logic             pick_any;
  logic [FW-1:0]    pick_idx;
  logic [BW-1:0]    pick_buf;
  logic [SW-1:0]    pick_slot;

  for (genvar f = 0; f < NSLOT; f++) begin : g_want
    assign want[f] = (slot_st[f] == SLOT_WANT);
  end

  sp_first_set #(.N(NSLOT)) u_issue_pick (
    .req (want),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign pick_buf  = BW'(int'(pick_idx) / DEPTH);
  assign pick_slot = SW'(int'(pick_idx) % DEPTH);

  // Miss history and LRU order
  logic          accept, do_serve, do_stall, do_miss, do_alloc, hist_hit;
  logic [AW-1:0] prev_addr;
  logic [BW-1:0] victim, lru_idx;

  assign prev_addr = miss_addr - AW'(1);

  sp_miss_history #(.AW(AW), .DEPTH(HIST)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .push       (do_miss),
    .push_addr  (miss_addr),
    .probe_addr (prev_addr),
    .probe_hit  (hist_hit)
  );

  sp_lru_rank #(.NBUF(NBUF)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch     (do_serve | do_alloc),
    .touch_idx (lru_idx),
    .victim    (victim)
  );

  // Service decode
  logic [BW-1:0] svc_buf;
  logic [FW-1:0] svc_slot;
  logic [SW-1:0] svc_head_nxt;
  logic          svc_ready;

  assign miss_ready   = (fsm_q == FSM_IDLE);
  assign accept       = miss_valid && miss_ready;
  assign svc_buf      = (fsm_q == FSM_WAIT) ? wait_buf_q : hit_buf;
  assign svc_slot     = flat(svc_buf, head_q[svc_buf]);
  assign svc_ready    = (slot_st[svc_slot] == SLOT_READY);
  assign svc_head_nxt = (head_q[svc_buf] == SW'(DEPTH - 1)) ? '0 : head_q[svc_buf] + 1'b1;
  assign do_serve     = svc_ready && ((accept && hit_any) || (fsm_q == FSM_WAIT));
  assign do_stall     = accept && hit_any && !svc_ready;
  assign do_miss      = accept && !hit_any;
  assign do_alloc     = do_miss && hist_hit;
  assign lru_idx      = do_alloc ? victim : svc_buf;

  // Fill decode
  logic [GW-1:0] f_gen;
  logic [BW-1:0] f_buf;
  logic [SW-1:0] f_slot;
  logic [FW-1:0] f_flat;
  logic          fill_ok;

  assign f_gen   = mem_fill_tag[TW-1 -: GW];
  assign f_buf   = mem_fill_tag[SW +: BW];
  assign f_slot  = mem_fill_tag[SW-1:0];
  assign f_flat  = flat(f_buf, f_slot);
  assign fill_ok = mem_fill_valid && (f_gen == gen_q[f_buf]) && (slot_st[f_flat] == SLOT_PEND);

  // Control state; later statements take precedence
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NSLOT; f++) slot_st[f] <= SLOT_EMPTY;
      for (int b = 0; b < NBUF; b++) begin
        head_q[b] <= '0;
        gen_q[b]  <= '0;
      end
      fsm_q         <= FSM_IDLE;
      wait_buf_q    <= '0;
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_tag   <= '0;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      if (pick_any) begin
        slot_st[pick_idx] <= SLOT_PEND;
        mem_req_valid     <= 1'b1;
        mem_req_addr      <= slot_addr[pick_idx];
        mem_req_tag       <= {gen_q[pick_buf], pick_buf, pick_slot};
      end
      if (fill_ok) slot_st[f_flat] <= SLOT_READY;
      if (do_serve) begin
        slot_st[svc_slot]   <= SLOT_WANT;
        slot_addr[svc_slot] <= slot_addr[svc_slot] + AW'(DEPTH);
        head_q[svc_buf]     <= svc_head_nxt;
        resp_valid          <= 1'b1;
        resp_hit            <= 1'b1;
        fsm_q               <= FSM_IDLE;
      end
      if (do_stall) begin
        fsm_q      <= FSM_WAIT;
        wait_buf_q <= hit_buf;
      end
      if (do_miss) begin
        resp_valid <= 1'b1;
        resp_hit   <= 1'b0;
      end
      if (do_alloc) begin
        for (int s = 0; s < DEPTH; s++) begin
          slot_st[flat(victim, SW'(s))]   <= SLOT_WANT;
          slot_addr[flat(victim, SW'(s))] <= miss_addr + AW'(s + 1);
        end
        head_q[victim] <= '0;
        gen_q[victim]  <= gen_q[victim] + 1'b1;
      end
    end
  end

  // Data array: one write port (fills), one synchronous read port
  always_ff @(posedge clk) begin
    if (fill_ok) data_mem[f_flat] <= mem_fill_data;
  end

  always_ff @(posedge clk) begin
    resp_data <= data_mem[svc_slot];
  end

endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic clk,
  input logic rst,
  input logic miss_valid,
  input logic miss_ready,
  input logic resp_valid,
  input logic resp_hit,
  input logic mem_req_valid
);

  // R1: first cycle out of reset is quiet and ready
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (miss_ready && !resp_valid && !mem_req_valid));

  // R2: every response follows an accepted miss or a stall
  p_resp_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(miss_valid && miss_ready) || $past(!miss_ready)));

  // R4: a miss answer comes straight after acceptance, never after a stall
  p_miss_direct_r4: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> $past(miss_valid && miss_ready));

  // R8: an accepted miss is answered next cycle or the block stalls
  p_answer_or_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> (resp_valid || !miss_ready));

  // R8: no answer while stalled
  p_quiet_in_stall_r8: assert property (@(posedge clk) disable iff (rst)
    !miss_ready |-> !resp_valid);

endmodule

bind stream_prefetch sp_checker u_sp_checker (
  .clk           (clk),
  .rst           (rst),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .resp_valid    (resp_valid),
  .resp_hit      (resp_hit),
  .mem_req_valid (mem_req_valid)
);

// File: tb/test_stream_prefetch.sv
module test_stream_prefetch;
  localparam int AW = 16, DW = 32, NBUF = 4, DEPTH = 2, HIST = 4, GW = 2;
  localparam int TW = 5, LAT = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic          miss_ready, resp_valid, resp_hit, mem_req_valid;
  logic [DW-1:0] resp_data;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] mem_req_tag;
  logic          mem_fill_valid = 1'b0;
  logic [TW-1:0] mem_fill_tag = '0;
  logic [DW-1:0] mem_fill_data = '0;

  stream_prefetch #(.AW(AW), .DW(DW), .NBUF(NBUF), .DEPTH(DEPTH), .HIST(HIST), .GW(GW))
  i_stream_prefetch (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_tag(mem_req_tag), .mem_fill_valid(mem_fill_valid),
    .mem_fill_tag(mem_fill_tag), .mem_fill_data(mem_fill_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit hold = 1'b0;

  // scoreboard of expected answers
  bit            exp_hit_q[$];
  logic [DW-1:0] exp_data_q[$];
  string         exp_req_q[$];
  // log of requests and memory in flight
  logic [AW-1:0] rlog_addr[$];
  logic [TW-1:0] rlog_tag[$];
  logic [AW-1:0] mq_addr[$];
  logic [TW-1:0] mq_tag[$];
  int            mq_due[$];

  function automatic logic [DW-1:0] blk_data(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  function automatic logic [TW-1:0] mk_tag(input int g, input int b, input int s);
    return {g[1:0], b[1:0], s[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) cyc++;

  // monitor, memory model and fill driver
  always @(negedge clk) begin
    mem_fill_valid = 1'b0;
    if (!rst) begin
      if (resp_valid) begin
        if (exp_hit_q.size() == 0) begin
          check(1'b0, "R2", "unexpected response", 1, 0);
        end else begin
          automatic bit            eh = exp_hit_q.pop_front();
          automatic logic [DW-1:0] ed = exp_data_q.pop_front();
          automatic string         er = exp_req_q.pop_front();
          check(resp_hit == eh, er, "resp_hit", resp_hit, eh);
          if (eh) check(resp_data == ed, er, "resp_data", resp_data, ed);
        end
      end
      if (mem_req_valid) begin
        rlog_addr.push_back(mem_req_addr);
        rlog_tag.push_back(mem_req_tag);
        mq_addr.push_back(mem_req_addr);
        mq_tag.push_back(mem_req_tag);
        mq_due.push_back(cyc + LAT);
      end
      if (!hold && mq_due.size() > 0 && mq_due[0] <= cyc) begin
        automatic logic [AW-1:0] a = mq_addr.pop_front();
        mem_fill_valid = 1'b1;
        mem_fill_tag   = mq_tag.pop_front();
        mem_fill_data  = blk_data(a);
        void'(mq_due.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: offers one miss and queues the expected answer
  task automatic send(input logic [AW-1:0] a, input bit hit, input string req);
    @(negedge clk);
    for (int w = 0; w < 200 && !miss_ready; w++) @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    exp_hit_q.push_back(hit);
    exp_data_q.push_back(blk_data(a));
    exp_req_q.push_back(req);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic expect_req(input logic [AW-1:0] a, input logic [TW-1:0] t, input string req);
    if (rlog_addr.size() == 0) begin
      check(1'b0, req, "missing request", 0, a);
    end else begin
      automatic logic [AW-1:0] ga = rlog_addr.pop_front();
      automatic logic [TW-1:0] gt = rlog_tag.pop_front();
      check(ga == a, req, "request address", ga, a);
      check(gt == t, req, "request tag", gt, t);
    end
  endtask

  task automatic expect_no_req(input string req);
    check(rlog_addr.size() == 0, req, "request count", rlog_addr.size(), 0);
    rlog_addr.delete();
    rlog_tag.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(miss_ready == 1'b1, "R1", "miss_ready", miss_ready, 1);
    check(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);

    // R1, R5: lone miss, no stream yet
    send(16'h0100, 1'b0, "R1");
    idle(6);
    expect_no_req("R5");

    // R5, R6, R7: consecutive miss opens a stream in buffer 3, generation 1
    send(16'h0101, 1'b0, "R4");
    idle(6);
    expect_req(16'h0102, mk_tag(1, 3, 0), "R6");
    expect_req(16'h0103, mk_tag(1, 3, 1), "R7");
    idle(10);

    // R10: second entry is not a head
    send(16'h0103, 1'b0, "R10");
    // R2, R3: head hits and refill one depth ahead
    send(16'h0102, 1'b1, "R2");
    idle(4);
    expect_req(16'h0104, mk_tag(1, 3, 0), "R3");
    send(16'h0103, 1'b1, "R2");
    idle(4);
    expect_req(16'h0105, mk_tag(1, 3, 1), "R3");
    idle(8);
    send(16'h0104, 1'b1, "R2");
    send(16'h0105, 1'b1, "R2");
    idle(4);
    expect_req(16'h0106, mk_tag(1, 3, 0), "R3");
    expect_req(16'h0107, mk_tag(1, 3, 1), "R3");

    // R4: unrelated miss, no allocation
    send(16'h0300, 1'b0, "R4");
    idle(6);
    expect_no_req("R4");
    idle(10);

    // R8: hit on a head whose data is held back
    hold = 1'b1;
    send(16'h0201, 1'b0, "R4");
    send(16'h0202, 1'b0, "R4");
    idle(6);
    expect_req(16'h0203, mk_tag(1, 2, 0), "R7");
    expect_req(16'h0204, mk_tag(1, 2, 1), "R6");
    send(16'h0203, 1'b1, "R8");
    idle(5);
    check(miss_ready == 1'b0, "R8", "miss_ready while pending", miss_ready, 0);
    check(exp_hit_q.size() == 1, "R8", "answers outstanding", exp_hit_q.size(), 1);
    hold = 1'b0;
    idle(20);
    check(exp_hit_q.size() == 0, "R8", "answers outstanding", exp_hit_q.size(), 0);
    expect_req(16'h0205, mk_tag(1, 2, 0), "R3");
    expect_no_req("R3");

    // R5: history holds HIST addresses, oldest leaves first
    send(16'h0400, 1'b0, "R4");
    send(16'h0500, 1'b0, "R4");
    send(16'h0600, 1'b0, "R4");
    send(16'h0700, 1'b0, "R4");
    send(16'h0800, 1'b0, "R4");
    send(16'h0401, 1'b0, "R5");
    idle(6);
    expect_no_req("R5");
    send(16'h0900, 1'b0, "R4");
    send(16'h0a00, 1'b0, "R4");
    send(16'h0b00, 1'b0, "R4");
    send(16'h0c00, 1'b0, "R4");
    send(16'h0901, 1'b0, "R5");
    idle(6);
    expect_req(16'h0902, mk_tag(1, 1, 0), "R5");
    expect_req(16'h0903, mk_tag(1, 1, 1), "R7");
    idle(10);

    // R7, R9: wrap through all buffers while fills are held
    hold = 1'b1;
    send(16'h0d00, 1'b0, "R4");
    send(16'h0d01, 1'b0, "R4");
    send(16'h1000, 1'b0, "R4");
    send(16'h1001, 1'b0, "R4");
    send(16'h1100, 1'b0, "R4");
    send(16'h1101, 1'b0, "R4");
    send(16'h1200, 1'b0, "R4");
    send(16'h1201, 1'b0, "R4");
    send(16'h1300, 1'b0, "R4");
    send(16'h1301, 1'b0, "R4");
    idle(6);
    expect_req(16'h0d02, mk_tag(1, 0, 0), "R7");
    expect_req(16'h0d03, mk_tag(1, 0, 1), "R7");
    expect_req(16'h1002, mk_tag(2, 3, 0), "R7");
    expect_req(16'h1003, mk_tag(2, 3, 1), "R6");
    expect_req(16'h1102, mk_tag(2, 2, 0), "R7");
    expect_req(16'h1103, mk_tag(2, 2, 1), "R6");
    expect_req(16'h1202, mk_tag(2, 1, 0), "R7");
    expect_req(16'h1203, mk_tag(2, 1, 1), "R6");
    expect_req(16'h1302, mk_tag(2, 0, 0), "R7");
    expect_req(16'h1303, mk_tag(2, 0, 1), "R6");
    hold = 1'b0;
    idle(40);
    send(16'h1302, 1'b1, "R9");
    send(16'h0d02, 1'b0, "R9");
    idle(10);

    check(exp_hit_q.size() == 0, "R2", "answers outstanding", exp_hit_q.size(), 0);
    summary();
    $finish;
  end

endmodule